// File: doc/BRIEF.md
# USB Host Wrapper Control Register File

This block is the software-visible control and status bank that sits beside a USB host controller. A processor reaches it over a simple register bus: a select strobe, a write flag, a byte address, 32-bit write data, combinational 32-bit read data and an error flag. Configuration registers drive output pins: bus filter bypass, port options, frame-length adjust, endianness, coherency and bus-master enable. Only whole 32-bit words are accessed, in little-endian byte order. An address whose low two bits are not zero matches no register.

An interrupt unit keeps two event flags. Flag 1 records a host system error. Flag 0 records an access to an address that matches no register. Software clears a flag by writing a 1 to it. A mask can be read but not written directly. It is cleared through an enable register and set through a disable register. One level interrupt line reports any flag that is set while its mask bit is clear. A control bit chooses whether an unmapped access returns a bus error or completes quietly.

Top module: `usbw_ctrl_regfile`

## Requirements
- R1: After reset the frame-length adjust reads 0x20, bus-master enable reads 1, the interrupt mask reads 0x3, and every other register and configuration output is 0.
- R2: A write to a configuration register updates its output pins on the next cycle and reads back the written field. Offsets: 0x30 bypass [3:0], 0x34 port options [4:0], 0x38 frame adjust [5:0], 0x40 endian [0], 0x44 coherency [0], 0x48 bus-master enable [0], 0x60 error-response enable [0].
- R3: Port option bit n (0 to 4) of the 0x34 word drives port_opts[n]. Bits above each field read as 0 and are never stored.
- R4: At 0x64, status bit 1 is host system error and bit 0 is unmapped access. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R5: A write to the mask at 0x68 leaves the mask unchanged.
- R6: A write to 0x6C clears each mask bit where the data holds a 1. Reads of 0x6C return 0.
- R7: A write to 0x70 sets each mask bit where the data holds a 1. Reads of 0x70 return 0.
- R8: irq is high exactly when some status bit is 1 and its mask bit is 0. It follows any register change in the cycle after that change.
- R9: A rising edge on host_err_in sets status bit 1. While the input stays high, no further edge is seen, so a cleared bit stays clear.
- R10: Any access, read or write, to an unmapped address sets status bit 0 on the next cycle. A write there changes no register, and a read there returns 0.
- R11: bus_err is 1 during an unmapped access when the error-response enable bit is 1. It is 0 for every other access.
- R12: If a host error edge and a write clearing status bit 1 fall in the same cycle, bit 1 ends up set.
- R13: An address whose two low bits are not zero is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Error response for the current access |
| host_err_in | input | 1 | Host system error event |
| filt_bypass | output | FILTER_W | Bus filter bypass field |
| port_opts | output | PORT_W | Port option bits |
| frame_adj | output | FLADJ_W | Frame-length adjust |
| big_endian | output | 1 | Endianness select |
| coherent | output | 1 | Coherent path enable |
| bus_master_en | output | 1 | Bus-master enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with ADDR_W = 8, so the bus reaches only 256 byte addresses. A full sweep of that space then covers every mapped offset, every gap and every misaligned address. The sweep runs twice: once with error responses off and once with them on. The frame-adjust, port and bypass fields are also swept over every value they can hold, with the reserved bits set. This makes read-back and pin mapping exhaustive for the default widths.

// File: rtl/usbw_cfg_pkg.sv
package usbw_cfg_pkg;
   localparam int REG_W     = 32;
   localparam int NUM_FLAGS = 4;    // 0 endian, 1 coherency, 2 bus master, 3 error response
   localparam int EVT_W     = 2;    // 1 host error, 0 unmapped access

   localparam logic [7:0] OFS_BYPASS = 8'h30;
   localparam logic [7:0] OFS_PORT   = 8'h34;
   localparam logic [7:0] OFS_FRAME  = 8'h38;
   localparam logic [7:0] OFS_ENDIAN = 8'h40;
   localparam logic [7:0] OFS_COHER  = 8'h44;
   localparam logic [7:0] OFS_MASTER = 8'h48;
   localparam logic [7:0] OFS_RSPCTL = 8'h60;
   localparam logic [7:0] OFS_EVSTAT = 8'h64;
   localparam logic [7:0] OFS_EVMASK = 8'h68;
   localparam logic [7:0] OFS_EVON   = 8'h6C;
   localparam logic [7:0] OFS_EVOFF  = 8'h70;

   typedef struct packed {
      logic                 bypass;
      logic                 port;
      logic                 frame;
      logic [NUM_FLAGS-1:0] flag;
      logic                 evstat;
      logic                 evmask;
      logic                 evon;
      logic                 evoff;
   } reg_hit_t;

   function automatic logic [7:0] flag_ofs(input int idx);
      case (idx)
         0:       return OFS_ENDIAN;
         1:       return OFS_COHER;
         2:       return OFS_MASTER;
         default: return OFS_RSPCTL;
      endcase
   endfunction
endpackage

// File: rtl/usbw_addr_dec.sv
module usbw_addr_dec
   import usbw_cfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit,
   output logic              unmapped
);
   logic                 hi_zero;
   logic [7:0]           lo;
   logic [NUM_FLAGS-1:0] flag_hit;

   assign lo = addr[7:0];

   if (ADDR_W > 8) begin : g_wide
      assign hi_zero = ~|addr[ADDR_W-1:8];
   end else begin : g_narrow
      assign hi_zero = 1'b1;
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      assign flag_hit[i] = hi_zero && (lo == flag_ofs(i));
   end

   always_comb begin
      hit.bypass = hi_zero && (lo == OFS_BYPASS);
      hit.port   = hi_zero && (lo == OFS_PORT);
      hit.frame  = hi_zero && (lo == OFS_FRAME);
      hit.flag   = flag_hit;
      hit.evstat = hi_zero && (lo == OFS_EVSTAT);
      hit.evmask = hi_zero && (lo == OFS_EVMASK);
      hit.evon   = hi_zero && (lo == OFS_EVON);
      hit.evoff  = hi_zero && (lo == OFS_EVOFF);
      unmapped   = !(hit.bypass || hit.port || hit.frame || (|flag_hit) ||
                     hit.evstat || hit.evmask || hit.evon || hit.evoff);
   end
endmodule

// File: rtl/usbw_cfg_bank.sv
module usbw_cfg_bank
   import usbw_cfg_pkg::*;
#(
   parameter int                   FILTER_W  = 4,
   parameter int                   PORT_W    = 5,
   parameter int                   FLADJ_W   = 6,
   parameter int                   DIN_W     = 6,
   parameter logic [FLADJ_W-1:0]   FLADJ_RST = 6'h20,
   parameter logic [NUM_FLAGS-1:0] FLAG_RST  = 4'b0100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic                 hit_bypass,
   input  logic                 hit_port,
   input  logic                 hit_frame,
   input  logic [NUM_FLAGS-1:0] hit_flag,
   input  logic [DIN_W-1:0]     wdata,
   output logic [FILTER_W-1:0]  bypass,
   output logic [PORT_W-1:0]    port,
   output logic [FLADJ_W-1:0]   frame,
   output logic [NUM_FLAGS-1:0] flags,
   output logic [REG_W-1:0]     rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bypass <= '0;
         port   <= '0;
         frame  <= FLADJ_RST;
      end else if (wr) begin
         if (hit_bypass) bypass <= wdata[FILTER_W-1:0];
         if (hit_port)   port   <= wdata[PORT_W-1:0];
         if (hit_frame)  frame  <= wdata[FLADJ_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                flags[i] <= FLAG_RST[i];
         else if (wr && hit_flag[i]) flags[i] <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_bypass) rdata[FILTER_W-1:0] = bypass;
      if (hit_port)   rdata[PORT_W-1:0]   = port;
      if (hit_frame)  rdata[FLADJ_W-1:0]  = frame;
      for (int i = 0; i < NUM_FLAGS; i++)
         if (hit_flag[i]) rdata[0] = flags[i];
   end

   // R2: frame adjust changes only through its own write
   p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && hit_frame) |=> $stable(frame));
   // R2: flag register takes bit 0 of the written word
   p_flag_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_flag[2]) |=> (flags[2] == $past(wdata[0])));
endmodule

// File: rtl/usbw_irq_unit.sv
module usbw_irq_unit
   import usbw_cfg_pkg::*;
#(
   parameter logic [EVT_W-1:0] MASK_RST = 2'b11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             hit_stat,
   input  logic             hit_mask,
   input  logic             hit_on,
   input  logic             hit_off,
   input  logic [EVT_W-1:0] wdata,
   input  logic             host_err_in,
   input  logic             unmapped_evt,
   output logic             irq,
   output logic [REG_W-1:0] rdata
);
   logic [EVT_W-1:0] stat, mask, set_v, clr_v;
   logic             host_q;

   assign set_v = {host_err_in & ~host_q, unmapped_evt};
   assign clr_v = (wr && hit_stat) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_q <= 1'b0;
         stat   <= '0;
         mask   <= MASK_RST;
      end else begin
         host_q <= host_err_in;
         stat   <= (stat & ~clr_v) | set_v;
         if (wr && hit_on)       mask <= mask & ~wdata;
         else if (wr && hit_off) mask <= mask | wdata;
      end
   end

   assign irq = |(stat & ~mask);

   always_comb begin
      rdata = '0;
      if (hit_stat) rdata[EVT_W-1:0] = stat;
      if (hit_mask) rdata[EVT_W-1:0] = mask;
   end

   // R4: a 1 written to a bit with no coincident event clears it
   p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_stat) |=> ((stat & $past(wdata & ~set_v)) == '0));
   // R12: an event always lands
   p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[1] |=> stat[1]);
   // R10: an unmapped access records bit 0
   p_unmapped_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_evt |=> stat[0]);
   // R5: the mask moves only through the enable and disable registers
   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (hit_on || hit_off)) |=> $stable(mask));
   // R6
   p_mask_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_on) |=> ((mask & $past(wdata)) == '0));
   // R7
   p_mask_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_off) |=> ((mask & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/usbw_ctrl_regfile.sv
module usbw_ctrl_regfile
   import usbw_cfg_pkg::*;
#(
   parameter int                 ADDR_W    = 8,
   parameter int                 FILTER_W  = 4,
   parameter int                 PORT_W    = 5,
   parameter int                 FLADJ_W   = 6,
   parameter logic [FLADJ_W-1:0] FLADJ_RST = 6'h20,
   parameter logic               BME_RST   = 1'b1,
   parameter logic [EVT_W-1:0]   MASK_RST  = 2'b11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   output logic                bus_err,
   input  logic                host_err_in,
   output logic [FILTER_W-1:0] filt_bypass,
   output logic [PORT_W-1:0]   port_opts,
   output logic [FLADJ_W-1:0]  frame_adj,
   output logic                big_endian,
   output logic                coherent,
   output logic                bus_master_en,
   output logic                irq
);
   localparam int MAX_FP = (FILTER_W > PORT_W) ? FILTER_W : PORT_W;
   localparam int DIN_W  = (MAX_FP > FLADJ_W) ? MAX_FP : FLADJ_W;
   localparam logic [NUM_FLAGS-1:0] FLAG_RST = {1'b0, BME_RST, 2'b00};

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 8..32");
   end
   if (FILTER_W < 1 || PORT_W < 1 || FLADJ_W < EVT_W || DIN_W > 16) begin : g_bad_width
      $error("field widths must lie in 1..16, frame adjust at least 2");
   end

   reg_hit_t             hit;
   logic                 unmapped, wr, access_bad;
   logic [NUM_FLAGS-1:0] flags;
   logic [REG_W-1:0]     cfg_rd, evt_rd;
   logic                 unused_wdata_hi;

   assign wr              = bus_sel && bus_wr;
   assign access_bad      = bus_sel && unmapped;
   assign unused_wdata_hi = ^bus_wdata[REG_W-1:DIN_W];

   usbw_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .hit(hit), .unmapped(unmapped)
   );

   usbw_cfg_bank #(
      .FILTER_W(FILTER_W), .PORT_W(PORT_W), .FLADJ_W(FLADJ_W),
      .DIN_W(DIN_W), .FLADJ_RST(FLADJ_RST), .FLAG_RST(FLAG_RST)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(wr),
      .hit_bypass(hit.bypass), .hit_port(hit.port), .hit_frame(hit.frame),
      .hit_flag(hit.flag), .wdata(bus_wdata[DIN_W-1:0]),
      .bypass(filt_bypass), .port(port_opts), .frame(frame_adj),
      .flags(flags), .rdata(cfg_rd)
   );

   usbw_irq_unit #(.MASK_RST(MASK_RST)) u_irq (
      .clk(clk), .rst_n(rst_n), .wr(wr),
      .hit_stat(hit.evstat), .hit_mask(hit.evmask),
      .hit_on(hit.evon), .hit_off(hit.evoff),
      .wdata(bus_wdata[EVT_W-1:0]), .host_err_in(host_err_in),
      .unmapped_evt(access_bad), .irq(irq), .rdata(evt_rd)
   );

   assign big_endian    = flags[0];
   assign coherent      = flags[1];
   assign bus_master_en = flags[2];
   assign bus_err       = access_bad && flags[3];
   assign bus_rdata     = bus_sel ? (cfg_rd | evt_rd) : '0;

   // R10: an unmapped read returns zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && unmapped) |-> (bus_rdata == '0));
   // R11: an error response never carries data
   p_err_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == '0));
endmodule

// File: tb/sim_usbw_ctrl_regfile.sv
module sim_usbw_ctrl_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err, host_err_in = 1'b0;
   logic [3:0]  filt_bypass;
   logic [4:0]  port_opts;
   logic [5:0]  frame_adj;
   logic        big_endian, coherent, bus_master_en, irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model of the register contents
   logic [3:0] m_byp;  logic [4:0] m_port; logic [5:0] m_frame;
   logic [3:0] m_flag; logic [1:0] m_stat; logic [1:0] m_mask;

   always #10 clk = ~clk;

   usbw_ctrl_regfile #(.ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .host_err_in(host_err_in), .filt_bypass(filt_bypass),
      .port_opts(port_opts), .frame_adj(frame_adj), .big_endian(big_endian),
      .coherent(coherent), .bus_master_en(bus_master_en), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit mapped(input logic [7:0] a);
      case (a)
         8'h30, 8'h34, 8'h38, 8'h40, 8'h44, 8'h48,
         8'h60, 8'h64, 8'h68, 8'h6C, 8'h70: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] model_rd(input logic [7:0] a);
      case (a)
         8'h30: return {28'd0, m_byp};
         8'h34: return {27'd0, m_port};
         8'h38: return {26'd0, m_frame};
         8'h40: return {31'd0, m_flag[0]};
         8'h44: return {31'd0, m_flag[1]};
         8'h48: return {31'd0, m_flag[2]};
         8'h60: return {31'd0, m_flag[3]};
         8'h64: return {30'd0, m_stat};
         8'h68: return {30'd0, m_mask};
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
      case (a)
         8'h30: m_byp   = d[3:0];
         8'h34: m_port  = d[4:0];
         8'h38: m_frame = d[5:0];
         8'h40: m_flag[0] = d[0];
         8'h44: m_flag[1] = d[0];
         8'h48: m_flag[2] = d[0];
         8'h60: m_flag[3] = d[0];
         8'h64: m_stat = m_stat & ~d[1:0];
         8'h6C: m_mask = m_mask & ~d[1:0];
         8'h70: m_mask = m_mask | d[1:0];
         default: ;
      endcase
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      #2 chk({req, " write err"}, {31'd0, bus_err}, {31'd0, !mapped(a) && m_flag[3]});
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      model_wr(a, d);
      if (!mapped(a)) m_stat[0] = 1'b1;
   endtask

   task automatic bus_read(input logic [7:0] a, input string req);
      logic [31:0] d; logic e;
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #2 d = bus_rdata; e = bus_err;
      @(negedge clk);
      bus_sel = 0;
      chk({req, " read"}, d, model_rd(a));
      chk("R11 read err", {31'd0, e}, {31'd0, !mapped(a) && m_flag[3]});
      if (!mapped(a)) m_stat[0] = 1'b1;
   endtask

   task automatic chk_pins(input string req);
      chk({req, " bypass"}, {28'd0, filt_bypass}, {28'd0, m_byp});
      chk({req, " port"},   {27'd0, port_opts},   {27'd0, m_port});
      chk({req, " frame"},  {26'd0, frame_adj},   {26'd0, m_frame});
      chk({req, " flags"},  {29'd0, bus_master_en, coherent, big_endian},
                            {29'd0, m_flag[2:0]});
      chk("R8 irq", {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] reg_list [11];
      reg_list = '{8'h30, 8'h34, 8'h38, 8'h40, 8'h44, 8'h48, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h70};
      m_byp = 0; m_port = 0; m_frame = 6'h20; m_flag = 4'b0100; m_stat = 0; m_mask = 2'b11;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_pins("R1");
      foreach (reg_list[i]) bus_read(reg_list[i], "R1");

      // R2, R3: exhaustive field sweeps with reserved bits set
      for (int v = 0; v < 16; v++) begin
         bus_write(8'h30, 32'hFFFF_FFF0 | v, "R2");
         chk_pins("R2"); bus_read(8'h30, "R3");
      end
      for (int v = 0; v < 32; v++) begin
         bus_write(8'h34, 32'h5A5A_5AE0 | v, "R3");
         chk_pins("R3"); bus_read(8'h34, "R3");
      end
      for (int v = 0; v < 64; v++) begin
         bus_write(8'h38, 32'hC3C3_C3C0 | v, "R2");
         chk_pins("R2"); bus_read(8'h38, "R3");
      end
      for (int v = 0; v < 2; v++) begin
         for (int k = 0; k < 3; k++) begin
            bus_write(reg_list[3 + k], 32'hFFFF_FFFE | v, "R2");
            chk_pins("R2"); bus_read(reg_list[3 + k], "R3");
         end
      end

      // R5: direct mask write ignored
      bus_write(8'h68, 32'h0, "R5");
      bus_read(8'h68, "R5");

      // R6: enable clears mask, reads zero
      bus_write(8'h6C, 32'hFFFF_FFFF, "R6");
      bus_read(8'h68, "R6"); bus_read(8'h6C, "R6");
      chk_pins("R6");

      // R9, R8: host error edge raises irq
      @(negedge clk); host_err_in = 1;
      @(negedge clk); m_stat[1] = 1;
      chk("R9 irq after edge", {31'd0, irq}, 32'd1);
      bus_read(8'h64, "R9");
      // R4: writing zero keeps it, writing one clears it while input stays high
      bus_write(8'h64, 32'hFFFF_FFFC, "R4");
      bus_read(8'h64, "R4");
      bus_write(8'h64, 32'h2, "R4");
      repeat (3) @(negedge clk);
      bus_read(8'h64, "R9 level held");
      chk_pins("R9");
      host_err_in = 0;

      // R7: disable sets mask bits, reads zero
      @(negedge clk); host_err_in = 1;
      @(negedge clk); host_err_in = 0; m_stat[1] = 1;
      bus_write(8'h70, 32'hFFFF_FFFE, "R7");
      chk_pins("R7");
      bus_read(8'h68, "R7"); bus_read(8'h70, "R7");
      bus_write(8'h6C, 32'h2, "R6");
      chk_pins("R8");
      bus_write(8'h64, 32'h3, "R4");
      chk_pins("R4");

      // R12: edge and clear in the same cycle
      @(negedge clk);
      host_err_in = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h64; bus_wdata = 32'h2;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; host_err_in = 0; m_stat[1] = 1;
      bus_read(8'h64, "R12");
      bus_write(8'h64, 32'h3, "R4");

      // R10, R13: unmapped write ignored
      bus_write(8'h3C, 32'hFFFF_FFFF, "R10");
      bus_write(8'h31, 32'hFFFF_FFFF, "R13");
      chk_pins("R10");
      foreach (reg_list[i]) bus_read(reg_list[i], "R10");
      bus_write(8'h64, 32'h1, "R4");

      // R10, R11, R13: full address sweeps, error response off then on
      for (int pass = 0; pass < 2; pass++) begin
         if (pass == 1) bus_write(8'h60, 32'h1, "R11");
         for (int a = 0; a < 256; a++) begin
            bus_read(a[7:0], mapped(a[7:0]) ? "R2" : "R10 R13");
            chk("R10 flag", {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
         end
         bus_write(8'h64, 32'h3, "R4");
         chk_pins("R4");
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule